// File: doc/BRIEF.md
# Interrupt Controller Mode Register

This block holds the 64-bit base-and-mode register of a per-processor interrupt controller. The register carries a page-aligned base address, a boot-processor flag, a global enable and an extended-addressing mode bit. Every write is screened against the allowed moves between the three operating modes: off, legacy and extended. A write that breaks a rule is dropped whole and flagged with a one-cycle error pulse. A write that passes replaces the base address and the mode bits. The boot-processor flag is never taken from the written data.

Two side effects leave the block as registered outputs. When the controller enters extended mode, a 32-bit logical ID is derived from the processor's initial ID and held. When a write turns the controller off, a one-cycle pulse tells the neighbouring spurious-vector register to drop its software-enable bit. The register bus and the interrupt logic sit outside this block.

Top module: `irq_mode_reg`

## Requirements
- R1: After reset `mode_q` reads as follows. Enable (bit 11) is 1. Extended (bit 10) is 0. The base address in bits 35:12 is 0xFEE00. Bit 8 equals `boot_strap`. Every other bit is 0. `logical_id`, `wr_reject` and `swen_clr` are 0. Bit 8 stays at its reset value until the next reset.
- R2: A write with data bit 10 set is rejected when `ext_supported` is 0.
- R3: A write with data bit 11 clear and data bit 10 set is rejected.
- R4: A write with bits 11 and 10 both set is rejected when the register is in the off mode (bit 11 = 0, bit 10 = 0).
- R5: A write with bit 11 set and bit 10 clear is rejected when the register is in extended mode (bits 11 and 10 both 1).
- R6: A rejected write leaves `mode_q` and `logical_id` unchanged. `wr_reject` is high for exactly the one cycle after the write edge.
- R7: An accepted write takes effect at its own clock edge. Bits 35:12, 11 and 10 are copied from `wr_data`. Bit 8 keeps its value whatever the data says. All other bits of `mode_q` read 0.
- R8: An accepted write with data bit 11 clear raises `swen_clr` for the one cycle after the write edge. No other write raises it.
- R9: An accepted write that moves bit 10 from 0 to 1 loads `logical_id`. Bits 31:16 take `init_id[19:4]`. In bits 15:0 exactly one bit is set, at the position given by `init_id[3:0]`.
- R10: The moves extended→off, legacy→off and off→legacy are accepted.
- R11: Without a write strobe no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_strap | input | 1 | Boot-processor strap, loaded into bit 8 at reset |
| ext_supported | input | 1 | Strap: extended mode is available |
| init_id | input | 32 | Initial processor ID used to derive the logical ID |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 64 | Write data |
| mode_q | output | 64 | Current register value |
| logical_id | output | 32 | Derived extended-mode logical ID |
| wr_reject | output | 1 | One-cycle pulse: the previous write was illegal |
| swen_clr | output | 1 | One-cycle pulse: clear the spurious-vector software enable |

## Verification
The assertions assume that `boot_strap` and `ext_supported` change only while reset is held and are steady for at least one clock before reset is released. The boot-flag and supported-mode properties compare against sampled past values, so this assumption matters to them. The bench changes both straps only inside a reset window of several cycles, and `ext_supported` is lowered only around a single write in a test that runs from legacy mode. Writes are single-cycle strobes driven on the falling edge, so every accepted or rejected move is seen as one clean transition.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int unsigned BSP_POS = 8;
  localparam int unsigned EXT_POS = 10;
  localparam int unsigned EN_POS  = 11;

  // operating mode, encoded as {enable, extended}
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_BAD    = 2'b01,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } irqm_mode_e;

  // reason a write was refused, in priority order
  typedef enum logic [2:0] {
    RULE_OK       = 3'd0,
    RULE_NOSUP    = 3'd1,
    RULE_BADSTATE = 3'd2,
    RULE_OFF2EXT  = 3'd3,
    RULE_EXT2LEG  = 3'd4
  } irqm_rule_e;

  function automatic irqm_mode_e mode_of(input logic en, input logic ext);
    return irqm_mode_e'({en, ext});
  endfunction

endpackage

// File: rtl/irqm_check.sv
module irqm_check (
  input  logic                  cur_en,
  input  logic                  cur_ext,
  input  logic                  req_en,
  input  logic                  req_ext,
  input  logic                  ext_ok,
  output logic                  legal,
  output irqm_pkg::irqm_rule_e  rule
);
  import irqm_pkg::*;

  irqm_mode_e cur_mode;
  irqm_mode_e req_mode;

  always_comb begin
    cur_mode = mode_of(cur_en, cur_ext);
    req_mode = mode_of(req_en, req_ext);
    rule     = RULE_OK;
    if (req_ext && !ext_ok) begin
      rule = RULE_NOSUP;
    end else if (req_mode == MODE_BAD) begin
      rule = RULE_BADSTATE;
    end else if ((cur_mode == MODE_OFF) && (req_mode == MODE_EXT)) begin
      rule = RULE_OFF2EXT;
    end else if ((cur_mode == MODE_EXT) && (req_mode == MODE_LEGACY)) begin
      rule = RULE_EXT2LEG;
    end
    legal = (rule == RULE_OK);
  end

endmodule

// File: rtl/irqm_lid.sv
module irqm_lid #(
  parameter int unsigned ID_W  = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned CL_W  = 16,
  localparam int unsigned MEMB_W = 1 << SEL_W,
  localparam int unsigned LID_W  = CL_W + MEMB_W
) (
  input  logic [ID_W-1:0]  init_id,
  output logic [LID_W-1:0] lid
);

  logic [SEL_W-1:0] member_sel;
  assign member_sel = init_id[SEL_W-1:0];

  // one-hot member bit inside the cluster
  for (genvar g = 0; g < MEMB_W; g++) begin : g_member
    assign lid[g] = (member_sel == SEL_W'(g));
  end

  // cluster number from the ID bits above the member select
  assign lid[MEMB_W +: CL_W] = init_id[SEL_W +: CL_W];

endmodule

// File: rtl/irqm_state.sv
module irqm_state #(
  parameter int unsigned BASE_W   = 24,
  parameter logic [BASE_W-1:0] RST_BASE = '0,
  parameter int unsigned LID_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  input  logic              wr_en,
  input  logic              legal,
  input  logic              req_en,
  input  logic              req_ext,
  input  logic [BASE_W-1:0] req_base,
  input  logic [LID_W-1:0]  lid_new,
  output logic              en_q,
  output logic              ext_q,
  output logic              bsp_q,
  output logic [BASE_W-1:0] base_q,
  output logic [LID_W-1:0]  lid_q,
  output logic              err_q,
  output logic              clr_q
);

  logic              upd;
  logic              lid_ld;
  logic              en_d;
  logic              ext_d;
  logic [BASE_W-1:0] base_d;
  logic [LID_W-1:0]  lid_d;
  logic              err_d;
  logic              clr_d;

  // next state
  always_comb begin
    upd    = wr_en & legal;
    lid_ld = upd & req_ext & ~ext_q;
    en_d   = en_q;
    ext_d  = ext_q;
    base_d = base_q;
    lid_d  = lid_q;
    if (upd) begin
      en_d   = req_en;
      ext_d  = req_ext;
      base_d = req_base;
    end
    if (lid_ld) begin
      lid_d = lid_new;
    end
    err_d = wr_en & ~legal;
    clr_d = upd & ~req_en;
  end

  // mode and address registers, enabled by an accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      ext_q  <= 1'b0;
      base_q <= RST_BASE;
    end else if (upd) begin
      en_q   <= en_d;
      ext_q  <= ext_d;
      base_q <= base_d;
    end
  end

  // boot flag: loaded from the strap while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsp_q <= boot_strap;
    end
  end

  // logical ID, loaded on entry to extended mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lid_q <= '0;
    end else if (lid_ld) begin
      lid_q <= lid_d;
    end
  end

  // single-cycle event pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      err_q <= err_d;
      clr_q <= clr_d;
    end
  end

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int unsigned REG_W    = 64,
  parameter int unsigned BASE_LSB = 12,
  parameter int unsigned BASE_MSB = 35,
  parameter logic [BASE_MSB:0] RST_ADDR = 36'h0_FEE0_0000,
  parameter int unsigned ID_W     = 32,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned CL_W     = 16,
  localparam int unsigned BASE_W  = BASE_MSB - BASE_LSB + 1,
  localparam int unsigned LID_W   = CL_W + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_strap,
  input  logic             ext_supported,
  input  logic [ID_W-1:0]  init_id,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q,
  output logic [LID_W-1:0] logical_id,
  output logic             wr_reject,
  output logic             swen_clr
);
  import irqm_pkg::*;

  localparam logic [BASE_W-1:0] RST_BASE = RST_ADDR[BASE_MSB:BASE_LSB];

  logic              req_en;
  logic              req_ext;
  logic [BASE_W-1:0] req_base;
  logic              legal;
  irqm_rule_e        rule;
  logic              en_q;
  logic              ext_q;
  logic              bsp_q;
  logic [BASE_W-1:0] base_q;
  logic [LID_W-1:0]  lid_new;

  assign req_en   = wr_data[EN_POS];
  assign req_ext  = wr_data[EXT_POS];
  assign req_base = wr_data[BASE_MSB:BASE_LSB];

  irqm_check u_check (
    .cur_en  (en_q),
    .cur_ext (ext_q),
    .req_en  (req_en),
    .req_ext (req_ext),
    .ext_ok  (ext_supported),
    .legal   (legal),
    .rule    (rule)
  );

  irqm_lid #(
    .ID_W  (ID_W),
    .SEL_W (SEL_W),
    .CL_W  (CL_W)
  ) u_lid (
    .init_id (init_id),
    .lid     (lid_new)
  );

  irqm_state #(
    .BASE_W   (BASE_W),
    .RST_BASE (RST_BASE),
    .LID_W    (LID_W)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_strap (boot_strap),
    .wr_en      (wr_en),
    .legal      (legal),
    .req_en     (req_en),
    .req_ext    (req_ext),
    .req_base   (req_base),
    .lid_new    (lid_new),
    .en_q       (en_q),
    .ext_q      (ext_q),
    .bsp_q      (bsp_q),
    .base_q     (base_q),
    .lid_q      (logical_id),
    .err_q      (wr_reject),
    .clr_q      (swen_clr)
  );

  // register image
  always_comb begin
    mode_q                    = '0;
    mode_q[BASE_MSB:BASE_LSB] = base_q;
    mode_q[EN_POS]            = en_q;
    mode_q[EXT_POS]           = ext_q;
    mode_q[BSP_POS]           = bsp_q;
  end

endmodule

// File: rtl/irqm_sva.sv
module irqm_sva #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned LID_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_supported,
  input logic             wr_en,
  input logic [REG_W-1:0] mode_q,
  input logic [LID_W-1:0] logical_id,
  input logic             wr_reject,
  input logic             swen_clr
);
  import irqm_pkg::*;

  // R3
  ext_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[EXT_POS] |-> mode_q[EN_POS]);

  // R2
  ext_rise_supported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[EXT_POS]) |-> $past(ext_supported));

  // R4
  ext_rise_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[EXT_POS]) |-> $past(mode_q[EN_POS]));

  // R5
  ext_fall_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[EXT_POS]) |-> !mode_q[EN_POS]);

  // R6
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> ($stable(mode_q) && $stable(logical_id)));

  // R6
  reject_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(wr_en));

  // R8
  clr_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swen_clr |-> (!mode_q[EN_POS] && $past(wr_en) && !wr_reject));

  // R9
  lid_member_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[EXT_POS] |-> ($countones(logical_id[15:0]) == 1));

  // R1
  boot_flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q[BSP_POS]));

  // R11
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(mode_q) && !wr_reject && !swen_clr));

endmodule

bind irq_mode_reg irqm_sva #(.REG_W(REG_W), .LID_W(LID_W)) u_irqm_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_supported (ext_supported),
  .wr_en         (wr_en),
  .mode_q        (mode_q),
  .logical_id    (logical_id),
  .wr_reject     (wr_reject),
  .swen_clr      (swen_clr)
);

// File: tb/test_irq_mode_reg.sv
module test_irq_mode_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] RST_ADDR = 36'h0_FEE0_0000;

  logic        clk;
  logic        rst_n;
  logic        boot_strap;
  logic        ext_supported;
  logic [31:0] init_id;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] mode_q;
  logic [31:0] logical_id;
  logic        wr_reject;
  logic        swen_clr;

  int checks;
  int failures;
  bit done;

  irq_mode_reg i_irq_mode_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_strap    (boot_strap),
    .ext_supported (ext_supported),
    .init_id       (init_id),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .mode_q        (mode_q),
    .logical_id    (logical_id),
    .wr_reject     (wr_reject),
    .swen_clr      (swen_clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] img(input logic en, input logic ext,
                                      input logic bsp, input logic [35:0] addr);
    logic [63:0] v;
    v = '0;
    v[35:12] = addr[35:12];
    v[11] = en;
    v[10] = ext;
    v[8]  = bsp;
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, input logic [31:0] id);
    @(negedge clk);
    rst_n = 1'b0;
    boot_strap = strap;
    ext_supported = 1'b1;
    init_id = id;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one write; returns after the write edge has settled
  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic after_next_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_reject(input string req, input logic [63:0] d,
                               input logic [63:0] exp_mode, input logic [31:0] exp_lid);
    do_write(d);
    chk(req, "mode kept", mode_q, exp_mode);
    chk("R6", "lid kept", 64'(logical_id), 64'(exp_lid));
    chk(req, "reject pulse", 64'(wr_reject), 64'd1);
    chk("R8", "no clear on reject", 64'(swen_clr), 64'd0);
    after_next_edge();
    chk("R6", "reject one cycle", 64'(wr_reject), 64'd0);
  endtask

  task automatic t_reset_state();
    chk("R1", "reset mode", mode_q, img(1'b1, 1'b0, 1'b1, RST_ADDR));
    chk("R1", "reset lid", 64'(logical_id), 64'd0);
    chk("R1", "reset reject", 64'(wr_reject), 64'd0);
    chk("R1", "reset clear", 64'(swen_clr), 64'd0);
  endtask

  task automatic t_idle();
    repeat (3) after_next_edge();
    chk("R11", "idle mode", mode_q, img(1'b1, 1'b0, 1'b1, RST_ADDR));
    chk("R11", "idle pulses", 64'({wr_reject, swen_clr}), 64'd0);
  endtask

  task automatic t_bad_state();
    expect_reject("R3", img(1'b0, 1'b1, 1'b0, 36'h0_1000_0000),
                  img(1'b1, 1'b0, 1'b1, RST_ADDR), 32'd0);
  endtask

  task automatic t_unsupported();
    @(negedge clk);
    ext_supported = 1'b0;
    expect_reject("R2", img(1'b1, 1'b1, 1'b1, RST_ADDR),
                  img(1'b1, 1'b0, 1'b1, RST_ADDR), 32'd0);
    @(negedge clk);
    ext_supported = 1'b1;
  endtask

  task automatic t_enter_ext();
    logic [63:0] d;
    d = img(1'b1, 1'b1, 1'b0, 36'h1_2345_6000);
    d[0] = 1'b1;
    d[63] = 1'b1;
    do_write(d);
    chk("R7", "ext mode image", mode_q, img(1'b1, 1'b1, 1'b1, 36'h1_2345_6000));
    chk("R9", "logical id", 64'(logical_id), 64'h0000_0000_ABCD_4000);
    chk("R7", "accepted no reject", 64'(wr_reject), 64'd0);
  endtask

  task automatic t_ext_to_legacy();
    expect_reject("R5", img(1'b1, 1'b0, 1'b1, RST_ADDR),
                  img(1'b1, 1'b1, 1'b1, 36'h1_2345_6000), 32'hABCD_4000);
  endtask

  task automatic t_disable();
    do_write(img(1'b0, 1'b0, 1'b0, RST_ADDR));
    chk("R10", "ext to off", mode_q, img(1'b0, 1'b0, 1'b1, RST_ADDR));
    chk("R8", "clear pulse", 64'(swen_clr), 64'd1);
    after_next_edge();
    chk("R8", "clear one cycle", 64'(swen_clr), 64'd0);
  endtask

  task automatic t_off_to_ext();
    expect_reject("R4", img(1'b1, 1'b1, 1'b1, RST_ADDR),
                  img(1'b0, 1'b0, 1'b1, RST_ADDR), 32'hABCD_4000);
  endtask

  task automatic t_off_to_legacy();
    do_write(img(1'b1, 1'b0, 1'b1, 36'h0_FEE0_0000));
    chk("R10", "off to legacy", mode_q, img(1'b1, 1'b0, 1'b1, RST_ADDR));
    chk("R8", "no clear when enabling", 64'(swen_clr), 64'd0);
    do_write(img(1'b0, 1'b0, 1'b0, 36'h0_0000_0000));
    chk("R10", "legacy to off", mode_q, img(1'b0, 1'b0, 1'b1, 36'h0));
    chk("R8", "clear from legacy", 64'(swen_clr), 64'd1);
  endtask

  task automatic t_second_reset();
    do_reset(1'b0, 32'h0000_0025);
    after_next_edge();
    chk("R1", "strap low", mode_q, img(1'b1, 1'b0, 1'b0, RST_ADDR));
    do_write(img(1'b1, 1'b1, 1'b1, RST_ADDR));
    chk("R7", "boot flag kept low", mode_q, img(1'b1, 1'b1, 1'b0, RST_ADDR));
    chk("R9", "lid small id", 64'(logical_id), 64'h0000_0000_0002_0020);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    boot_strap = 1'b1;
    ext_supported = 1'b1;
    init_id = 32'h000A_BCDE;
    wr_en = 1'b0;
    wr_data = '0;
    do_reset(1'b1, 32'h000A_BCDE);
    after_next_edge();
    t_reset_state();
    t_idle();
    t_bad_state();
    t_unsupported();
    t_enter_ext();
    t_ext_to_legacy();
    t_disable();
    t_off_to_ext();
    t_off_to_legacy();
    t_second_reset();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule